// File: doc/BRIEF.md
# Shortened Hamming Single-Error Codec

This block is a purely combinational (6,3) error-control codec with a built-in channel model. A 3-bit data word is encoded into a 6-bit word that carries three parity bits. That word then passes through a per-bit error injector, where each line is XORed with its own mask bit. The decoder forms a 3-bit syndrome from the received word. It turns the syndrome into one-hot select lines, inverts the single line that was flagged and pulls the three data bits out of the repaired word.

The encoder, the received word, the syndrome and the decoded data are all visible on the ports. This lets any pattern of up to six channel errors be applied and its effect on the data be observed directly.

The code is shortened, so one nonzero syndrome value (7) names no bit position. The decoder leaves the word untouched for that value and raises a separate flag. Nothing is clocked and nothing is stored, so every output follows the inputs within the same evaluation.

Top module: `sec63_codec`

## Requirements
- R1: Codeword bit i (0-based) carries 1-based position i+1. The layout is codeOut[0]=P1, codeOut[1]=P2, codeOut[2]=D1, codeOut[3]=P3, codeOut[4]=D2, codeOut[5]=D3, where D1=dataIn[0], D2=dataIn[1] and D3=dataIn[2]. The parity bits are P1=D1^D2, P2=D1^D3 and P3=D2^D3.
- R2: rxWord equals codeOut XOR errMask, bit for bit.
- R3: syndrome[0] = r1^r3^r5, syndrome[1] = r2^r3^r6 and syndrome[2] = r4^r5^r6, where rN = rxWord[N-1]. The syndrome therefore equals the XOR of the 1-based positions of all set bits of the received word.
- R4: When errMask is zero, the syndrome is 0, corrected and uncorrectable are both low, and dataOut equals dataIn.
- R5: For each of the six single-bit masks, the syndrome equals the flipped position, corrected is high and dataOut equals dataIn.
- R6: When the syndrome is 7, no bit is inverted, uncorrectable is high, corrected is low, and dataOut is {rxWord[5], rxWord[4], rxWord[2]}.
- R7: corrected and uncorrectable are never high together. corrected is high exactly when the syndrome is in 1..6, and at most one received bit is inverted.
- R8: For any mask of two to six errors, dataOut equals bits 2, 4 and 5 of rxWord after the bit at the syndrome position (if 1..6) is inverted. This includes miscorrections.
- R9: The block holds no state. The outputs change with the inputs and need no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dataIn | input | 3 | Data word to encode (bit 0 = D1) |
| errMask | input | 6 | Per-line error injection, 1 flips that codeword bit |
| codeOut | output | 6 | Encoded word before the channel |
| rxWord | output | 6 | Word after error injection |
| syndrome | output | 3 | Decoder syndrome |
| corrected | output | 1 | A single bit was inverted |
| uncorrectable | output | 1 | Syndrome names no position (value 7) |
| dataOut | output | 3 | Decoded data word |

## Verification
Some properties are checked by assertions at every evaluation:
- the decoder's select lines stay one-hot or empty;
- the two flags never rise together;
- the channel output differs from the encoder output exactly where the mask is set;
- any repaired word has a zero syndrome unless the syndrome was 7;
- clean and single-error inputs always give back the data.

The bench has to show the rest. It confirms the exact codeword layout and the syndrome-7 pass-through with its data value. It also predicts the data value for every multi-error miscorrection, across all 8 data words and all 64 masks. Finally, it confirms that outputs move without a clock edge.

// File: rtl/sec63_pkg.sv
package sec63_pkg;

  localparam int DATA_W = 3;

  function automatic int parityBitsFor(int dataBits);
    for (int r = 1; r < 16; r++) begin
      if ((1 << r) >= dataBits + r + 1) return r;
    end
    return 16;
  endfunction

  localparam int SYN_W  = parityBitsFor(DATA_W);
  localparam int CODE_W = DATA_W + SYN_W;
  localparam int LINE_N = 1 << SYN_W;

  // strobes from the syndrome control to the repair datapath
  typedef struct packed {
    logic [CODE_W-1:0] flipLine;
    logic              corrected;
    logic              uncorrectable;
  } fixCtrl_t;

  function automatic bit isParityPos(int pos);
    return (pos & (pos - 1)) == 0;
  endfunction

  // 1-based codeword position holding data bit idx
  function automatic int dataPos(int idx);
    int cnt;
    cnt = 0;
    for (int p = 1; p <= CODE_W; p++) begin
      if (!isParityPos(p)) begin
        if (cnt == idx) return p;
        cnt++;
      end
    end
    return 0;
  endfunction

  // positions checked by syndrome bit k
  function automatic logic [CODE_W-1:0] coverMask(int k);
    logic [CODE_W-1:0] m;
    m = '0;
    for (int p = 1; p <= CODE_W; p++) begin
      if (((p >> k) & 1) == 1) m[p-1] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/sec63_encoder.sv
module sec63_encoder
  import sec63_pkg::*;
(
  input  logic [DATA_W-1:0] dataIn,
  output logic [CODE_W-1:0] codeOut
);

  logic [SYN_W-1:0] parityBit;

  always_comb begin
    for (int k = 0; k < SYN_W; k++) begin
      parityBit[k] = 1'b0;
      for (int i = 0; i < DATA_W; i++) begin
        if (((dataPos(i) >> k) & 1) == 1) parityBit[k] = parityBit[k] ^ dataIn[i];
      end
    end
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_data
    assign codeOut[dataPos(i)-1] = dataIn[i];
  end

  for (genvar k = 0; k < SYN_W; k++) begin : g_par
    assign codeOut[(1 << k) - 1] = parityBit[k];
  end

endmodule

// File: rtl/sec63_channel.sv
module sec63_channel
  import sec63_pkg::*;
(
  input  logic [CODE_W-1:0] txWord,
  input  logic [CODE_W-1:0] errMask,
  output logic [CODE_W-1:0] rxWord
);

  for (genvar b = 0; b < CODE_W; b++) begin : g_line
    assign rxWord[b] = txWord[b] ^ errMask[b];
  end

endmodule

// File: rtl/sec63_datapath.sv
module sec63_datapath
  import sec63_pkg::*;
(
  input  logic [DATA_W-1:0] dataIn,
  input  logic [CODE_W-1:0] errMask,
  input  fixCtrl_t          fix,
  output logic [CODE_W-1:0] codeOut,
  output logic [CODE_W-1:0] rxWord,
  output logic [SYN_W-1:0]  syndrome,
  output logic [DATA_W-1:0] dataOut
);

  logic [CODE_W-1:0] fixedWord;

  sec63_encoder u_enc (
    .dataIn (dataIn),
    .codeOut(codeOut)
  );

  sec63_channel u_chan (
    .txWord (codeOut),
    .errMask(errMask),
    .rxWord (rxWord)
  );

  for (genvar k = 0; k < SYN_W; k++) begin : g_syn
    localparam logic [CODE_W-1:0] COVER = coverMask(k);
    assign syndrome[k] = ^(rxWord & COVER);
  end

  assign fixedWord = rxWord ^ fix.flipLine;

  for (genvar i = 0; i < DATA_W; i++) begin : g_extract
    assign dataOut[i] = fixedWord[dataPos(i)-1];
  end

  // independent re-check of the repaired word
  logic [SYN_W-1:0] checkSyn;
  always_comb begin
    for (int k = 0; k < SYN_W; k++) checkSyn[k] = ^(fixedWord & coverMask(k));
  end

  always_comb begin
    assert_channel_diff_R2: assert ((rxWord ^ codeOut) == errMask)
      else $error("channel output does not match mask");
    assert_repair_clean_R5: assert (fix.uncorrectable || checkSyn == '0)
      else $error("repaired word keeps a nonzero syndrome");
  end

endmodule

// File: rtl/sec63_fixctrl.sv
module sec63_fixctrl
  import sec63_pkg::*;
(
  input  logic [SYN_W-1:0] syndrome,
  output fixCtrl_t         fix
);

  logic [LINE_N-1:0] selLine;

  always_comb begin
    selLine = '0;
    selLine[syndrome] = 1'b1;
  end

  for (genvar p = 1; p <= CODE_W; p++) begin : g_map
    assign fix.flipLine[p-1] = selLine[p];
  end

  assign fix.corrected = |fix.flipLine;

  if (CODE_W + 1 < LINE_N) begin : g_short
    assign fix.uncorrectable = |selLine[LINE_N-1:CODE_W+1];
  end else begin : g_perfect
    assign fix.uncorrectable = 1'b0;
  end

  always_comb begin
    assert_flip_onehot_R7: assert ($onehot0(fix.flipLine))
      else $error("more than one line selected for inversion");
    assert_flags_exclusive_R7: assert (!(fix.corrected && fix.uncorrectable))
      else $error("corrected and uncorrectable together");
    assert_zero_syn_idle_R4: assert (syndrome != '0 || (!fix.corrected && !fix.uncorrectable))
      else $error("zero syndrome raised a flag");
  end

endmodule

// File: rtl/sec63_codec.sv
module sec63_codec
  import sec63_pkg::*;
(
  input  logic [2:0] dataIn,
  input  logic [5:0] errMask,
  output logic [5:0] codeOut,
  output logic [5:0] rxWord,
  output logic [2:0] syndrome,
  output logic       corrected,
  output logic       uncorrectable,
  output logic [2:0] dataOut
);

  fixCtrl_t fix;

  sec63_datapath u_dp (
    .dataIn  (dataIn),
    .errMask (errMask),
    .fix     (fix),
    .codeOut (codeOut),
    .rxWord  (rxWord),
    .syndrome(syndrome),
    .dataOut (dataOut)
  );

  sec63_fixctrl u_ctrl (
    .syndrome(syndrome),
    .fix     (fix)
  );

  assign corrected     = fix.corrected;
  assign uncorrectable = fix.uncorrectable;

  always_comb begin
    assert_clean_pass_R4: assert (errMask != '0 || (dataOut == dataIn && syndrome == '0))
      else $error("clean word altered");
    assert_single_fix_R5: assert ($countones(errMask) != 1 || (corrected && dataOut == dataIn))
      else $error("single error not repaired");
  end

endmodule

// File: tb/sec63_codec_tb.sv
module sec63_codec_tb;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] dataIn = '0;
  logic [5:0] errMask = '0;
  logic [5:0] codeOut, rxWord;
  logic [2:0] syndrome, dataOut;
  logic corrected, uncorrectable;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sec63_codec u_dut (
    .dataIn(dataIn), .errMask(errMask), .codeOut(codeOut), .rxWord(rxWord),
    .syndrome(syndrome), .corrected(corrected), .uncorrectable(uncorrectable),
    .dataOut(dataOut)
  );

  function automatic int refEnc(int d);
    int d1, d2, d3;
    d1 = d & 1; d2 = (d >> 1) & 1; d3 = (d >> 2) & 1;
    return (d1 ^ d2) | ((d1 ^ d3) << 1) | (d1 << 2) | ((d2 ^ d3) << 3) | (d2 << 4) | (d3 << 5);
  endfunction

  function automatic int refSyn(int rx);
    int s;
    s = 0;
    for (int pos = 1; pos <= 6; pos++) if (((rx >> (pos - 1)) & 1) == 1) s = s ^ pos;
    return s;
  endfunction

  function automatic int refDec(int rx);
    int s, w;
    s = refSyn(rx);
    w = rx;
    if (s >= 1 && s <= 6) w = w ^ (1 << (s - 1));
    return ((w >> 2) & 1) | (((w >> 4) & 1) << 1) | (((w >> 5) & 1) << 2);
  endfunction

  task automatic checkVal(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d (data=%0d mask=%0d)",
               tag, what, act, exp, dataIn, errMask);
    end
  endtask

  task automatic applyVec(int d, int m);
    @(posedge clk);
    #1;
    dataIn = 3'(d);
    errMask = 6'(m);
    @(negedge clk);
  endtask

  task automatic checkAll(int d, int m);
    int enc, rx, s, dec, w;
    string tagD;
    enc = refEnc(d);
    rx = enc ^ m;
    s = refSyn(rx);
    dec = refDec(rx);
    w = $countones(6'(m));
    if (w == 0) tagD = "R4";
    else if (w == 1) tagD = "R5";
    else if (s == 7) tagD = "R6";
    else tagD = "R8";
    checkVal("R1", "codeOut", int'(codeOut), enc);
    checkVal("R2", "rxWord", int'(rxWord), rx);
    checkVal("R3", "syndrome", int'(syndrome), s);
    checkVal(tagD, "dataOut", int'(dataOut), dec);
    checkVal("R7", "corrected", int'(corrected), (s >= 1 && s <= 6) ? 1 : 0);
    checkVal("R7", "uncorrectable", int'(uncorrectable), (s == 7) ? 1 : 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // reset window: inputs held at zero, outputs must be all zero
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkVal("R4", "reset codeOut", int'(codeOut), 0);
    checkVal("R4", "reset dataOut", int'(dataOut), 0);
    checkVal("R4", "reset flags", int'({corrected, uncorrectable}), 0);
    rstN = 1'b1;

    // directed R6: positions 1,2,4 wrong -> syndrome 7, data untouched
    applyVec(0, 6'b001011);
    checkVal("R6", "syn7 uncorrectable", int'(uncorrectable), 1);
    checkVal("R6", "syn7 corrected", int'(corrected), 0);
    checkVal("R6", "syn7 dataOut", int'(dataOut), 0);
    // directed R6: positions 3,4 wrong -> syndrome 7, D1 passes through flipped
    applyVec(0, 6'b001100);
    checkVal("R6", "syn7 D1 raw", int'(dataOut), 1);
    checkVal("R6", "syn7 rxWord", int'(rxWord), 12);

    // directed R5: each single error on data 5
    for (int b = 0; b < 6; b++) begin
      applyVec(5, 1 << b);
      checkVal("R5", "single syndrome", int'(syndrome), b + 1);
      checkVal("R5", "single dataOut", int'(dataOut), 5);
    end

    // R9: inputs change between edges, outputs follow without a clock edge
    applyVec(2, 0);
    #1;
    dataIn = 3'd6;
    errMask = 6'b000100;
    #1;
    checkVal("R9", "no-clock codeOut", int'(codeOut), refEnc(6));
    checkVal("R9", "no-clock dataOut", int'(dataOut), 6);
    checkVal("R9", "no-clock corrected", int'(corrected), 1);

    // exhaustive sweep against the reference model
    for (int d = 0; d < 8; d++) begin
      for (int m = 0; m < 64; m++) begin
        applyVec(d, m);
        checkAll(d, m);
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule